// File: doc/BRIEF.md
# Buffered Parallel-In Serial-Out Shifter

This block turns a parallel word into a serial bit stream through two register stages. A holding register takes a snapshot of the parallel bus whenever its capture strobe rises. A separate shift chain of the same width can be zeroed, filled from the holding register, or advanced by one place with a fresh serial bit entering at the low end. The top stage of the chain is the only output.

Because the two stages are independent, the next word can be snapshotted while the current one is still being shifted out. Both strobes are level signals that the block samples in its system clock domain. A 0-to-1 change between two consecutive samples counts as one edge, so a strobe held high acts only once. Clear and load are active-low levels that are sampled on every system clock edge. They override shifting and never touch the holding register.

Top module: `buf_piso_shifter`

## Requirements
- R1: A capture edge (cap_strobe sampled 1 with its previous sample 0) copies par_in into the holding register. Without one, the holding register keeps its value.
- R2: A shift edge (shf_strobe sampled 1 after 0), with clr_n and ld_n both high, moves every chain stage up by one index. Stage 0 takes ser_in.
- R3: clr_n low at a clock edge zeroes every chain stage, even when ld_n is low or a shift edge occurs in the same cycle.
- R4: ld_n low with clr_n high copies the holding register into the chain, overriding a shift edge. par_in[0] maps to stage 0 and par_in[WIDTH-1] to the output stage, so a loaded word leaves most significant bit first.
- R5: clr_n and ld_n leave the holding register unchanged.
- R6: With clr_n and ld_n high and no shift edge, the chain holds its state.
- R7: A strobe held high over many cycles gives exactly one capture or one shift. A new action needs the strobe to return low first.
- R8: When a capture edge and a load fall in the same cycle, the chain receives the old holding-register word. The new word can be loaded from the next cycle on.
- R9: After reset the holding register, the chain and both strobe samples are zero, and ser_out reads 0.
- R10: ser_out always equals the top chain stage, one clock after the action that set that stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_in | input | WIDTH | Parallel word; bit 0 feeds stage 0 |
| cap_strobe | input | 1 | Capture strobe level; a rise snapshots par_in |
| shf_strobe | input | 1 | Shift strobe level; a rise advances the chain |
| clr_n | input | 1 | Active-low chain clear, highest priority |
| ld_n | input | 1 | Active-low load of the chain from the holding register |
| ser_in | input | 1 | Serial bit entering stage 0 on a shift |
| ser_out | output | 1 | Top chain stage |

## Verification
The bench first targets a strobe held high while the parallel bus changes. A design that acts on levels rather than edges would re-capture the bus or shift on every cycle. It then asserts clear together with load and a shift edge. A wrong priority would leave loaded or shifted data in the chain where zeros are expected. It also raises a capture in the same cycle as a load. A design that bypasses the holding register would load the new word instead of the old one. Finally it clears and reloads without a new capture. A design whose clear reaches the holding register would then shift out zeros instead of the kept word.

// File: rtl/buf_piso_pkg.sv
package buf_piso_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } chain_op_e;

  // Rising edge between two consecutive samples of a strobe level.
  function automatic logic rise_of(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  // Priority: clear, then load, then shift, else hold.
  function automatic chain_op_e pick_op(input logic clr_n, input logic ld_n,
                                        input logic shf_evt);
    if (!clr_n)       return OP_CLEAR;
    else if (!ld_n)   return OP_LOAD;
    else if (shf_evt) return OP_SHIFT;
    else              return OP_HOLD;
  endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic evt_o
);
  import buf_piso_pkg::*;

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign evt_o = rise_of(level_i, prev_q);
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_evt,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_o <= '0;
    else if (cap_evt) q_o <= d_i;
  end
endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  buf_piso_pkg::chain_op_e  op_i,
  input  logic                     ser_i,
  input  logic [WIDTH-1:0]         load_i,
  output logic [WIDTH-1:0]         q_o
);
  import buf_piso_pkg::*;

  logic [WIDTH-1:0] up_src;

  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign up_src[g] = ser_i;
    end else begin : g_rest
      assign up_src[g] = q_o[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_o[g] <= 1'b0;
      end else begin
        unique case (op_i)
          OP_CLEAR: q_o[g] <= 1'b0;
          OP_LOAD:  q_o[g] <= load_i[g];
          OP_SHIFT: q_o[g] <= up_src[g];
          default:  q_o[g] <= q_o[g];
        endcase
      end
    end
  end
endmodule

// File: rtl/buf_piso_shifter.sv
module buf_piso_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] par_in,
  input  logic             cap_strobe,
  input  logic             shf_strobe,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic             ser_in,
  output logic             ser_out
);
  import buf_piso_pkg::*;

  localparam int TOP = WIDTH - 1;

  logic             cap_evt;
  logic             shf_evt;
  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] shift_q;
  chain_op_e        chain_op;

  strobe_edge u_cap_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (cap_strobe),
    .evt_o   (cap_evt)
  );

  strobe_edge u_shf_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (shf_strobe),
    .evt_o   (shf_evt)
  );

  hold_reg #(.WIDTH(WIDTH)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_evt (cap_evt),
    .d_i     (par_in),
    .q_o     (store_q)
  );

  assign chain_op = pick_op(clr_n, ld_n, shf_evt);

  shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (chain_op),
    .ser_i  (ser_in),
    .load_i (store_q),
    .q_o    (shift_q)
  );

  assign ser_out = shift_q[TOP];
endmodule

// File: rtl/buf_piso_chk.sv
module buf_piso_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] par_in,
  input logic             ser_in,
  input logic             clr_n,
  input logic             ld_n,
  input logic             cap_evt,
  input logic             shf_evt,
  input logic [WIDTH-1:0] store_q,
  input logic [WIDTH-1:0] shift_q,
  input logic             ser_out
);
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> store_q == $past(par_in));

  p_store_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(store_q));

  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && shf_evt) |=>
      shift_q == {$past(shift_q[WIDTH-2:0]), $past(ser_in)});

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (shift_q == '0) && !ser_out);

  p_load_r4_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !ld_n) |=> shift_q == $past(store_q));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && !shf_evt) |=> $stable(shift_q));

  p_one_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shf_evt |=> !shf_evt);

  p_one_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> !cap_evt);

  p_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ser_out == shift_q[WIDTH-1]);
endmodule

bind buf_piso_shifter buf_piso_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .par_in  (par_in),
  .ser_in  (ser_in),
  .clr_n   (clr_n),
  .ld_n    (ld_n),
  .cap_evt (cap_evt),
  .shf_evt (shf_evt),
  .store_q (store_q),
  .shift_q (shift_q),
  .ser_out (ser_out)
);

// File: tb/buf_piso_shifter_tb.sv
module buf_piso_shifter_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         cap_strobe = 1'b0;
  logic         shf_strobe = 1'b0;
  logic         clr_n = 1'b1;
  logic         ld_n = 1'b1;
  logic         ser_in = 1'b0;
  logic         ser_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench model state
  logic [W-1:0] m_hold = '0;
  logic [W-1:0] m_chain = '0;
  logic         m_pcap = 1'b0;
  logic         m_pshf = 1'b0;

  always #2.5 clk = ~clk;

  buf_piso_shifter #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .par_in(par_in), .cap_strobe(cap_strobe),
    .shf_strobe(shf_strobe), .clr_n(clr_n), .ld_n(ld_n), .ser_in(ser_in),
    .ser_out(ser_out)
  );

  function automatic logic [W-1:0] model_chain(input logic [W-1:0] cur,
      input logic [W-1:0] hold, input logic c_n, input logic l_n,
      input logic sh_e, input logic si);
    if (c_n == 1'b0) return '0;
    if (l_n == 1'b0) return hold;
    if (sh_e)        return {cur[W-2:0], si};
    return cur;
  endfunction

  function automatic string auto_tag(input logic c_n, input logic l_n,
                                     input logic sh_e, input logic cp_e);
    if (!c_n)          return "R3";
    if (!l_n && cp_e)  return "R8";
    if (!l_n)          return "R4";
    if (sh_e)          return "R2";
    return "R6";
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: ser_out=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at a falling edge, update model at the rising edge, check at the next fall.
  task automatic step(input logic [W-1:0] p, input logic c, input logic s,
                      input logic cl, input logic ld, input logic si,
                      input string tag);
    logic cap_e, shf_e;
    string t;
    par_in = p; cap_strobe = c; shf_strobe = s; clr_n = cl; ld_n = ld; ser_in = si;
    @(posedge clk);
    cap_e = c & ~m_pcap;
    shf_e = s & ~m_pshf;
    m_chain = model_chain(m_chain, m_hold, cl, ld, shf_e, si);
    if (cap_e) m_hold = p;
    m_pcap = c;
    m_pshf = s;
    t = (tag == "") ? auto_tag(cl, ld, shf_e, cap_e) : tag;
    @(negedge clk);
    check(ser_out, m_chain[W-1], t);
  endtask

  // Shift the whole chain out with strobe pulses (R4 ordering, R10 output).
  task automatic drain(input string tag);
    for (int i = 0; i < W; i++) begin
      step(par_in, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, tag);
      step(par_in, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0597));
    repeat (3) @(negedge clk);
    check(ser_out, 1'b0, "R9");
    rst_n = 1'b1;
    @(negedge clk);
    check(ser_out, 1'b0, "R9");

    // R1/R7: capture A5, hold strobe high while bus changes -> no recapture
    step(8'hA5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R1");
    for (int i = 0; i < 4; i++) step(8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
    step(8'h3C, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
    step(8'h3C, 1'b0, 1'b0, 1'b1, 0, 1'b0, "R4");
    drain("R4");
    // R7: shift strobe held high shifts once only
    step(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
    step(8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R2");
    for (int i = 0; i < 5; i++) step(8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
    step(8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
    drain("R7");
    // R3: clear beats load and shift
    step(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
    step(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
    step(8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    drain("R3");
    // R5: clear and load left the holding word intact
    step(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
    drain("R5");
    // R8: capture 5A and load in one cycle -> old A5, then 5A next cycle
    step(8'h5A, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    drain("R8");
    step(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    drain("R8");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] p;
      logic c, s, cl, ld, si;
      p  = W'($urandom);
      c  = (($urandom % 4) == 0) ? ~cap_strobe : cap_strobe;
      s  = (($urandom % 2) == 0) ? ~shf_strobe : shf_strobe;
      cl = (($urandom % 20) != 0);
      ld = (($urandom % 10) != 0);
      si = 1'($urandom);
      step(p, c, s, cl, ld, si, "");
    end

    // R9: reset in the middle of activity
    step(8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R1");
    step(8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
    rst_n = 1'b0;
    m_hold = '0; m_chain = '0; m_pcap = 1'b0; m_pshf = 1'b0;
    cap_strobe = 1'b0; shf_strobe = 1'b0; ld_n = 1'b1; clr_n = 1'b1;
    @(negedge clk);
    check(ser_out, 1'b0, "R9");
    rst_n = 1'b1;
    step(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
    drain("R9");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule